// File: doc/BRIEF.md
# Loss-of-Lock Controller with Loop Retuning

This block decides whether a clock-and-data-recovery receiver has lost lock and keeps the recovery loop's acquisition settings in step with that decision. Two detection methods are available. A jitter comparator checks a measured jitter word against a programmable threshold, with a hold band at equality. Alternatively, the block takes a loss-of-lock flag from an external frequency comparator. The choice depends on a 2-bit method field and on whether the receiver runs with a reference clock.

When the jitter method is in use, the block also writes to the loop's configuration registers. After reset it writes the acquisition-gain register once. Then, every time the lock flag changes, it writes either an acquisition value or a tracking value to the loop-filter register. While the flag is high, the receiver keeps trying to reacquire lock. Write requests wait in a small queue and leave through a ready/valid port, at most one per cycle. The frequency method issues none of these writes.

Top module: `lol_retune_ctrl`

## Requirements
- R1: While rst_n is low, lol_out and wr_valid are 0.
- R2: The jitter method is active when ref_mode is 0, or when ref_mode is 1 and method_sel is 01 or 11. The frequency method is active when ref_mode is 1 and method_sel is 00 or 10.
- R3: Under the jitter method, lol_out becomes 1 one clock after jit_meas is sampled above jit_thresh, and becomes 0 one clock after jit_meas is sampled below it.
- R4: Under the jitter method, jit_meas equal to jit_thresh leaves lol_out unchanged.
- R5: Under the frequency method, lol_out equals the value freq_lol_in had at the previous clock edge.
- R6: After each reset, exactly one write with address 77 (0x4D) and data 0x0D is issued, ahead of all other writes. It is queued on the first clock at which the jitter method is active, and lol_out holds its value at that clock.
- R7: Under the jitter method, each 0-to-1 change of lol_out queues a write of data 0x98 to address 98 (0x62). Each 1-to-0 change queues a write of data 0x00 to the same address.
- R8: While the frequency method is active, no write is queued.
- R9: A write is transferred at a clock edge where wr_valid and wr_ready are both 1. While wr_valid is 1 and wr_ready is 0, wr_valid, wr_addr and wr_data stay stable. Writes leave in the order they were queued.
- R10: Under the jitter method, if a change of lol_out is due while the queue is full, lol_out holds its value until the queue has space.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| jit_meas | input | JW | Measured jitter word |
| jit_thresh | input | JW | Jitter threshold for loss of lock |
| freq_lol_in | input | 1 | Loss-of-lock flag from the frequency comparator |
| method_sel | input | 2 | Method-select field |
| ref_mode | input | 1 | 1 when the receiver runs with a reference clock |
| lol_out | output | 1 | Loss-of-lock flag |
| wr_valid | output | 1 | A configuration write is offered |
| wr_ready | input | 1 | The configuration side accepts the write |
| wr_addr | output | 8 | Configuration register address |
| wr_data | output | 8 | Configuration register data |

## Verification
The bench builds the block with a 6-bit jitter word and a write queue only two entries deep. With that depth, two unacknowledged lock changes fill the queue, so the stall on a full queue can be reached within a few cycles of holding wr_ready low. The short jitter word keeps the threshold and equality patterns easy to read. A second reset that starts in frequency mode shows that the one-time gain write is deferred until the jitter method becomes active, and that it still comes first.

// File: rtl/lol_pkg.sv
package lol_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_item_t;

  // Frequency comparator is used only with a reference clock and field 00 or 10.
  function automatic logic use_freq_method(input logic ref_mode, input logic [1:0] sel);
    return ref_mode && (sel == 2'b00 || sel == 2'b10);
  endfunction
endpackage

// File: rtl/lol_detect.sv
module lol_detect #(
  parameter int JW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [JW-1:0] jit_meas,
  input  logic [JW-1:0] jit_thresh,
  input  logic          freq_lol_in,
  input  logic [1:0]    method_sel,
  input  logic          ref_mode,
  input  logic          hold,
  output logic          jit_sel,
  output logic          lol,
  output logic          rise_req,
  output logic          fall_req
);
  import lol_pkg::*;

  // Hysteresis-free compare with hold at equality.
  function automatic logic jit_next(input logic cur, input logic [JW-1:0] m, input logic [JW-1:0] t);
    if (m > t) return 1'b1;
    if (m < t) return 1'b0;
    return cur;
  endfunction

  logic nxt_j;

  always_comb begin
    jit_sel  = !use_freq_method(ref_mode, method_sel);
    nxt_j    = jit_next(lol, jit_meas, jit_thresh);
    rise_req = jit_sel && !lol && nxt_j;
    fall_req = jit_sel && lol && !nxt_j;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lol <= 1'b0;
    else if (!jit_sel) lol <= freq_lol_in;
    else if (!hold)   lol <= nxt_j;
  end
endmodule

// File: rtl/lol_wr_seq.sv
module lol_wr_seq #(
  parameter logic [7:0] INIT_ADDR  = 8'd77,
  parameter logic [7:0] INIT_DATA  = 8'h0D,
  parameter logic [7:0] LOOP_ADDR  = 8'd98,
  parameter logic [7:0] ACQ_DATA   = 8'h98,
  parameter logic [7:0] TRACK_DATA = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              jit_sel,
  input  logic              rise_req,
  input  logic              fall_req,
  input  logic              q_full,
  output logic              hold,
  output logic              init_pend,
  output logic              push_vld,
  output lol_pkg::wr_item_t push_item
);
  import lol_pkg::*;

  logic edge_req, push_init;

  always_comb begin
    edge_req  = rise_req || fall_req;
    push_init = jit_sel && init_pend && !q_full;
    hold      = jit_sel && (init_pend || (q_full && edge_req));
    push_vld  = push_init || (jit_sel && !init_pend && edge_req && !q_full);
    if (push_init)     push_item = '{addr: INIT_ADDR, data: INIT_DATA};
    else if (rise_req) push_item = '{addr: LOOP_ADDR, data: ACQ_DATA};
    else               push_item = '{addr: LOOP_ADDR, data: TRACK_DATA};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         init_pend <= 1'b1;
    else if (push_init) init_pend <= 1'b0;
  end
endmodule

// File: rtl/lol_wr_fifo.sv
module lol_wr_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         not_empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full      = (cnt == CW'(DEPTH));
    not_empty = (cnt != '0);
    do_push   = push && !full;
    do_pop    = pop && not_empty;
    dout      = mem[rp];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end
endmodule

// File: rtl/lol_retune_ctrl.sv
module lol_retune_ctrl #(
  parameter int         JW         = 12,
  parameter int         DEPTH      = 4,
  parameter logic [7:0] INIT_ADDR  = 8'd77,
  parameter logic [7:0] INIT_DATA  = 8'h0D,
  parameter logic [7:0] LOOP_ADDR  = 8'd98,
  parameter logic [7:0] ACQ_DATA   = 8'h98,
  parameter logic [7:0] TRACK_DATA = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [JW-1:0] jit_meas,
  input  logic [JW-1:0] jit_thresh,
  input  logic          freq_lol_in,
  input  logic [1:0]    method_sel,
  input  logic          ref_mode,
  output logic          lol_out,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [7:0]    wr_addr,
  output logic [7:0]    wr_data
);
  import lol_pkg::*;

  localparam int IW = $bits(wr_item_t);

  // Named internal events, also observed by the bound checker.
  logic     jit_sel, rise_req, fall_req, hold, init_pend;
  logic     push_vld, q_full;
  wr_item_t push_item, head;
  logic [IW-1:0] head_bits;

  lol_detect #(.JW(JW)) u_det (
    .clk(clk), .rst_n(rst_n), .jit_meas(jit_meas), .jit_thresh(jit_thresh),
    .freq_lol_in(freq_lol_in), .method_sel(method_sel), .ref_mode(ref_mode),
    .hold(hold), .jit_sel(jit_sel), .lol(lol_out),
    .rise_req(rise_req), .fall_req(fall_req)
  );

  lol_wr_seq #(
    .INIT_ADDR(INIT_ADDR), .INIT_DATA(INIT_DATA), .LOOP_ADDR(LOOP_ADDR),
    .ACQ_DATA(ACQ_DATA), .TRACK_DATA(TRACK_DATA)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .jit_sel(jit_sel), .rise_req(rise_req),
    .fall_req(fall_req), .q_full(q_full), .hold(hold), .init_pend(init_pend),
    .push_vld(push_vld), .push_item(push_item)
  );

  lol_wr_fifo #(.W(IW), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .push(push_vld), .din(push_item),
    .pop(wr_ready), .dout(head_bits), .not_empty(wr_valid), .full(q_full)
  );

  assign head    = wr_item_t'(head_bits);
  assign wr_addr = head.addr;
  assign wr_data = head.data;
endmodule

// File: rtl/lol_retune_chk.sv
module lol_retune_chk #(
  parameter int         JW         = 12,
  parameter logic [7:0] INIT_ADDR  = 8'd77,
  parameter logic [7:0] INIT_DATA  = 8'h0D,
  parameter logic [7:0] LOOP_ADDR  = 8'd98,
  parameter logic [7:0] ACQ_DATA   = 8'h98,
  parameter logic [7:0] TRACK_DATA = 8'h00
) (
  input logic          clk,
  input logic          rst_n,
  input logic [JW-1:0] jit_meas,
  input logic [JW-1:0] jit_thresh,
  input logic          freq_lol_in,
  input logic          lol_out,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [7:0]    wr_addr,
  input logic [7:0]    wr_data,
  input logic          jit_sel,
  input logic          rise_req,
  input logic          fall_req,
  input logic          init_pend,
  input logic          q_full,
  input logic          push_vld,
  input logic [15:0]   push_item
);
  always @(posedge clk) begin
    if (!rst_n) assert_reset_quiet_R1: assert (!lol_out && !wr_valid);
  end

  assert_equal_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (jit_sel && jit_meas == jit_thresh) |=> $stable(lol_out));

  assert_freq_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !jit_sel |=> (lol_out == $past(freq_lol_in)));

  assert_init_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (jit_sel && init_pend && !q_full) |-> (push_vld && push_item == {INIT_ADDR, INIT_DATA}));

  assert_rise_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_req && !init_pend && !q_full) |-> (push_vld && push_item == {LOOP_ADDR, ACQ_DATA}));

  assert_fall_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_req && !init_pend && !q_full) |-> (push_vld && push_item == {LOOP_ADDR, TRACK_DATA}));

  assert_no_push_freq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !jit_sel |-> !push_vld);

  assert_valid_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  assert_full_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (jit_sel && q_full && (rise_req || fall_req)) |=> $stable(lol_out));
endmodule

bind lol_retune_ctrl lol_retune_chk #(
  .JW(JW), .INIT_ADDR(INIT_ADDR), .INIT_DATA(INIT_DATA), .LOOP_ADDR(LOOP_ADDR),
  .ACQ_DATA(ACQ_DATA), .TRACK_DATA(TRACK_DATA)
) u_chk (
  .clk(clk), .rst_n(rst_n), .jit_meas(jit_meas), .jit_thresh(jit_thresh),
  .freq_lol_in(freq_lol_in), .lol_out(lol_out), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .jit_sel(jit_sel),
  .rise_req(rise_req), .fall_req(fall_req), .init_pend(init_pend), .q_full(q_full),
  .push_vld(push_vld), .push_item(push_item)
);

// File: tb/tb_lol_retune_ctrl.sv
module tb_lol_retune_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int JW = 6;
  localparam int DEPTH = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [JW-1:0] jit_meas = '0, jit_thresh = 6'd20;
  logic          freq_lol_in = 1'b0, ref_mode = 1'b0, wr_ready = 1'b1;
  logic [1:0]    method_sel = 2'b00;
  logic          lol_out, wr_valid;
  logic [7:0]    wr_addr, wr_data;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [15:0] exp_q[$];

  lol_retune_ctrl #(.JW(JW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .jit_meas(jit_meas), .jit_thresh(jit_thresh),
    .freq_lol_in(freq_lol_in), .method_sel(method_sel), .ref_mode(ref_mode),
    .lol_out(lol_out), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_wr(input logic [7:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Monitor: a transfer happens at the next edge when valid and ready are both high.
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      if (exp_q.size() == 0) check("R8/R9 unexpected write", {wr_addr, wr_data}, 16'hxxxx);
      else check("R6/R7/R9 write order", {wr_addr, wr_data}, exp_q.pop_front());
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: quiet during reset
    edges(3);
    #3;
    check("R1 lol in reset", {15'd0, lol_out}, 16'd0);
    check("R1 valid in reset", {15'd0, wr_valid}, 16'd0);
    // R6: referenceless, jitter low -> init write first
    expect_wr(8'h4D, 8'h0D);
    jit_meas = 6'd5;
    @(negedge clk); rst_n = 1'b1;
    edges(3);
    check("R3 low jitter keeps lol 0", {15'd0, lol_out}, 16'd0);
    // R3: above threshold
    jit_meas = 6'd30;
    expect_wr(8'h62, 8'h98);
    edges(1);
    check("R3 lol rises one clock after", {15'd0, lol_out}, 16'd1);
    // R4: equal holds high
    jit_meas = 6'd20;
    edges(3);
    check("R4 equal holds 1", {15'd0, lol_out}, 16'd1);
    // R3: below clears
    jit_meas = 6'd19;
    expect_wr(8'h62, 8'h00);
    edges(1);
    check("R3 lol falls one clock after", {15'd0, lol_out}, 16'd0);
    jit_meas = 6'd20;
    edges(3);
    check("R4 equal holds 0", {15'd0, lol_out}, 16'd0);
    // R2/R5/R8: reference mode, field 00 -> frequency method, no writes
    ref_mode = 1'b1; method_sel = 2'b00; jit_meas = 6'd40;
    freq_lol_in = 1'b1;
    edges(1);
    check("R5 freq lol follows 1 (sel 00)", {15'd0, lol_out}, 16'd1);
    freq_lol_in = 1'b0;
    edges(1);
    check("R5 freq lol follows 0 (sel 00)", {15'd0, lol_out}, 16'd0);
    method_sel = 2'b10; freq_lol_in = 1'b1;
    edges(1);
    check("R2 sel 10 uses freq", {15'd0, lol_out}, 16'd1);
    freq_lol_in = 1'b0; jit_meas = 6'd0;
    edges(2);
    check("R8 no write in freq mode", {15'd0, wr_valid}, 16'd0);
    // R2: reference mode with field 01 forces jitter method
    method_sel = 2'b01; freq_lol_in = 1'b1; jit_meas = 6'd50;
    expect_wr(8'h62, 8'h98);
    edges(1);
    check("R2 sel 01 uses jitter", {15'd0, lol_out}, 16'd1);
    edges(3);
    check("R9 queue drained", exp_q.size(), 16'd0);
    // R10: back-pressure with a two-entry queue
    wr_ready = 1'b0;
    jit_meas = 6'd1; expect_wr(8'h62, 8'h00); edges(1);
    jit_meas = 6'd60; expect_wr(8'h62, 8'h98); edges(1);
    check("R9 valid held", {15'd0, wr_valid}, 16'd1);
    jit_meas = 6'd1;
    edges(3);
    check("R10 stall while full", {15'd0, lol_out}, 16'd1);
    expect_wr(8'h62, 8'h00);
    wr_ready = 1'b1;
    edges(3);
    check("R10 update after space", {15'd0, lol_out}, 16'd0);
    edges(4);
    check("R9 all writes delivered", exp_q.size(), 16'd0);
    // R6: reset in frequency mode, init deferred until jitter method
    rst_n = 1'b0; ref_mode = 1'b1; method_sel = 2'b00; freq_lol_in = 1'b0;
    edges(2);
    rst_n = 1'b1;
    edges(3);
    check("R6 no init in freq mode", {15'd0, wr_valid}, 16'd0);
    ref_mode = 1'b0; jit_meas = 6'd63;
    expect_wr(8'h4D, 8'h0D);
    expect_wr(8'h62, 8'h98);
    edges(1);
    check("R6 lol held during init", {15'd0, lol_out}, 16'd0);
    edges(1);
    check("R6 lol rises after init", {15'd0, lol_out}, 16'd1);
    edges(4);
    check("R6 init then rise delivered", exp_q.size(), 16'd0);
    finish_run();
  end
endmodule